// File: doc/BRIEF.md
# Dual 8-bit Compare-Match Timer

Two independent 8-bit up-counters share one small register bus. Each channel has a compare constant, a control byte and two sticky status flags, and it drives one output pin. A counter advances when its selected count-enable pulse is high. The control byte picks that pulse from a shared vector of single-cycle strobes: prescale taps or edges of an outside clock, both made elsewhere. A selector value of zero halts the counter.

When a counter becomes equal to its constant, the channel raises a compare flag. Depending on its control byte, the channel can also clear the counter and set, reset or toggle its pin. A counter can instead be cleared by an edge of its external reset line. Wrapping from 0xFF to 0x00 raises the overflow flag.

The bus treats the two channels as the two bytes of 16-bit words. Byte enables allow software to reach either channel alone or both at once.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both counters read 0x00, both constants read 0xFF, both control bytes read 0x00, both status bytes read 0x00, and both output pins are 0.
- R2: Control bits [2:0] choose the count source. Value k in 1..7 makes the counter increase by 1 at each clock edge where `src_pulse[k-1]` is high. Value 0 holds the counter still.
- R3: A count that takes the counter from 0xFF to 0x00 sets status bit 1, the overflow flag, at that same edge.
- R4: Compare runs on every cycle. The first cycle in which the counter equals the constant is a match event, and status bit 0, the compare flag, is set at the end of that cycle.
- R5: In a cycle where the bus writes a channel's constant, that channel can produce no match event.
- R6: Control bits [4:3] select the clear source. With value 01, a match event clears the counter at the next edge.
- R7: With clear value 10, a rising edge on that channel's `ext_rst` line clears the counter. With value 11, a falling edge clears it. Edges of the other polarity have no effect.
- R8: Control bits [6:5] set what happens to the pin on a match event: 00 leaves it as it is, 01 drives 0, 10 drives 1, 11 toggles. The pin changes at the edge that ends the match cycle.
- R9: A status flag is sticky. It is cleared only by writing 0 to its bit after a status read has returned that bit as 1. A hardware set in the same cycle as the clear wins. A status write ends the armed state.
- R10: Word address 0 holds the counters, 1 the constants, 2 the control bytes and 3 the status bytes. Bits [15:8] (`bus_be[1]`) belong to channel 0 and bits [7:0] (`bus_be[0]`) to channel 1. A write touches only the lanes that are enabled.
- R11: A bus write to a counter takes priority over a clear and over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_be | input | 2 | Byte lane enables: [1] channel 0, [0] channel 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; arms the status flags for clearing |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| src_pulse | input | 7 | Shared single-cycle count-enable strobes |
| ext_rst | input | 2 | External clear lines, one per channel ([0] is channel 0) |
| tmr_out | output | 2 | Compare-driven output pins ([0] is channel 0) |

## Verification
Several pairs of actions can land in the same clock cycle. A count can arrive together with a bus write to the counter, and the write must win. A constant write can coincide with the first cycle of equality, and the match must be lost. A flag clear can arrive in the cycle where hardware sets the same flag, and the set must win. The bench creates each collision by driving both stimuli at one falling edge. After the following edge it reads the counter, the status byte and the pins through the bus.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int SRC_W = 3;
  localparam int CTL_W = 7;

  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_COR = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [1:0] A_ST  = 2'd3;

  localparam int ST_CMF = 0;
  localparam int ST_OVF = 1;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_MATCH = 2'b01,
    CLR_RISE  = 2'b10,
    CLR_FALL  = 2'b11
  } clr_e;

  typedef enum logic [1:0] {
    OS_KEEP   = 2'b00,
    OS_LOW    = 2'b01,
    OS_HIGH   = 2'b10,
    OS_TOGGLE = 2'b11
  } os_e;

  typedef struct packed {
    os_e              osel;
    clr_e             clr;
    logic [SRC_W-1:0] src;
  } ctl_t;

  // pin level after a match event
  function automatic logic pin_after_match(os_e sel, logic cur);
    case (sel)
      OS_LOW:    return 1'b0;
      OS_HIGH:   return 1'b1;
      OS_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

  // edge of the external clear line that the clear field asks for
  function automatic logic ext_clear_hit(clr_e sel, logic now, logic prev);
    case (sel)
      CLR_RISE: return now & ~prev;
      CLR_FALL: return ~now & prev;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            ext_rst,
  input  logic [DW-1:0]   wd,
  input  logic            cnt_we,
  input  logic            cor_we,
  input  logic            ctl_we,
  input  logic            st_we,
  input  logic            st_rd,
  output logic [DW-1:0]   cnt_q,
  output logic [DW-1:0]   cor_q,
  output ctl_t            ctl_q,
  output logic [1:0]      st_q,
  output logic            tout
);

  localparam logic [DW-1:0] CNT_TOP = '1;

  logic       tick;
  logic       eq_now, eq_q;
  logic       match_evt;
  logic       ext_q;
  logic       clr_evt;
  logic       wrap_evt;
  logic [1:0] set_req, clr_req, armed;

  // count source selection
  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (ctl_q.src == SRC_W'(k + 1)) tick = src_pulse[k];
  end

  assign eq_now    = (cnt_q == cor_q) && !cor_we;
  assign match_evt = eq_now && !eq_q;

  assign clr_evt = ((ctl_q.clr == CLR_MATCH) && match_evt) ||
                   ext_clear_hit(ctl_q.clr, ext_rst, ext_q);

  assign wrap_evt = tick && !clr_evt && !cnt_we && (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cor_q <= '1;
      ctl_q <= '0;
      eq_q  <= 1'b0;
      ext_q <= 1'b0;
      tout  <= 1'b0;
    end else begin
      eq_q  <= eq_now;
      ext_q <= ext_rst;
      if (cnt_we)       cnt_q <= wd;
      else if (clr_evt) cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
      if (cor_we) cor_q <= wd;
      if (ctl_we) ctl_q <= ctl_t'(wd[CTL_W-1:0]);
      if (match_evt) tout <= pin_after_match(ctl_q.osel, tout);
    end
  end

  // sticky flags with read-then-write-zero clearing
  always_comb begin
    set_req          = '0;
    set_req[ST_CMF]  = match_evt;
    set_req[ST_OVF]  = wrap_evt;
    clr_req          = {2{st_we}} & ~wd[1:0] & armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      armed <= '0;
    end else begin
      st_q <= set_req | (st_q & ~clr_req);
      if (st_we)      armed <= '0;
      else if (st_rd) armed <= armed | st_q;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && !clr_evt && cnt_q != CNT_TOP) |=> cnt_q == DW'($past(cnt_q) + 1'b1));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (st_q[ST_OVF] && cnt_q == '0));

  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> st_q[ST_CMF]);

  assert_write_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cor_we |-> !match_evt);

  assert_match_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ctl_q.clr == CLR_MATCH && !cnt_we) |=> cnt_q == '0);

  assert_drive_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ctl_q.osel == OS_LOW) |=> !tout);

  assert_pin_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt |=> $stable(tout));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_OVF] && !st_we) |=> st_q[ST_OVF]);

  assert_cpu_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wd));

endmodule

// File: rtl/dct_regbus.sv
module dct_regbus
  import dct_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bus_addr,
  input  logic [NCH-1:0]          bus_be,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [NCH*DW-1:0]       bus_wdata,
  output logic [NCH*DW-1:0]       bus_rdata,
  input  logic [NCH-1:0][DW-1:0]  rd_cnt,
  input  logic [NCH-1:0][DW-1:0]  rd_cor,
  input  logic [NCH-1:0][DW-1:0]  rd_ctl,
  input  logic [NCH-1:0][1:0]     rd_st,
  output logic [NCH-1:0][DW-1:0]  ch_wd,
  output logic [NCH-1:0]          cnt_we,
  output logic [NCH-1:0]          cor_we,
  output logic [NCH-1:0]          ctl_we,
  output logic [NCH-1:0]          st_we,
  output logic [NCH-1:0]          st_rd
);

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    // channel 0 sits in the most significant lane
    localparam int LANE = NCH - 1 - i;
    logic wsel;
    logic [DW-1:0] rbyte;

    assign wsel      = bus_wr && bus_be[LANE];
    assign ch_wd[i]  = bus_wdata[LANE*DW +: DW];
    assign cnt_we[i] = wsel && (bus_addr == A_CNT);
    assign cor_we[i] = wsel && (bus_addr == A_COR);
    assign ctl_we[i] = wsel && (bus_addr == A_CTL);
    assign st_we[i]  = wsel && (bus_addr == A_ST);
    assign st_rd[i]  = bus_rd && bus_be[LANE] && (bus_addr == A_ST);

    always_comb begin
      case (bus_addr)
        A_CNT:   rbyte = rd_cnt[i];
        A_COR:   rbyte = rd_cor[i];
        A_CTL:   rbyte = rd_ctl[i];
        default: rbyte = {{(DW-2){1'b0}}, rd_st[i]};
      endcase
    end
    assign bus_rdata[LANE*DW +: DW] = rbyte;

    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cnt_we[i], cor_we[i], ctl_we[i], st_we[i]}));
  end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic [1:0]      bus_be,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [2*DW-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_pulse,
  input  logic [1:0]      ext_rst,
  output logic [1:0]      tmr_out
);

  localparam int NCH = 2;

  logic [NCH-1:0][DW-1:0] rd_cnt, rd_cor, rd_ctl, ch_wd;
  logic [NCH-1:0][1:0]    rd_st;
  logic [NCH-1:0]         cnt_we, cor_we, ctl_we, st_we, st_rd;
  ctl_t                   ctl_arr [NCH];

  dct_regbus #(.DW(DW), .NCH(NCH)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rd_cnt    (rd_cnt),
    .rd_cor    (rd_cor),
    .rd_ctl    (rd_ctl),
    .rd_st     (rd_st),
    .ch_wd     (ch_wd),
    .cnt_we    (cnt_we),
    .cor_we    (cor_we),
    .ctl_we    (ctl_we),
    .st_we     (st_we),
    .st_rd     (st_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dct_channel #(.DW(DW), .NSRC(NSRC)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_pulse (src_pulse),
      .ext_rst   (ext_rst[i]),
      .wd        (ch_wd[i]),
      .cnt_we    (cnt_we[i]),
      .cor_we    (cor_we[i]),
      .ctl_we    (ctl_we[i]),
      .st_we     (st_we[i]),
      .st_rd     (st_rd[i]),
      .cnt_q     (rd_cnt[i]),
      .cor_q     (rd_cor[i]),
      .ctl_q     (ctl_arr[i]),
      .st_q      (rd_st[i]),
      .tout      (tmr_out[i])
    );
    assign rd_ctl[i] = {{(DW-CTL_W){1'b0}}, ctl_arr[i]};
  end

endmodule

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0]  src_pulse = '0;
  logic [1:0]  ext_rst = '0;
  logic [1:0]  tmr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_pulse(src_pulse), .ext_rst(ext_rst),
    .tmr_out(tmr_out)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_strobe(logic [1:0] a);
    @(negedge clk);
    bus_addr = a; bus_be = 2'b11; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse(int k, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); src_pulse[k] = 1'b1;
      @(negedge clk); src_pulse[k] = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    peek(2'd0, v); check("R1 counters", v, 16'h0000);
    peek(2'd1, v); check("R1 constants", v, 16'hFFFF);
    peek(2'd2, v); check("R1 control", v, 16'h0000);
    peek(2'd3, v); check("R1 status", v, 16'h0000);
    check("R1 pins", {14'd0, tmr_out}, 16'h0000);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr(2'd2, 2'b11, 16'h0103);
    pulse(0, 5); pulse(2, 2); pulse(1, 3);
    peek(2'd0, v); check("R2 per-source counting", v, 16'h0502);
    wr(2'd0, 2'b10, 16'hFE77);
    peek(2'd0, v); check("R10 upper-lane byte write", v, 16'hFE02);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    pulse(0, 2);
    peek(2'd0, v); check("R3 wrap to zero", v, 16'h0002);
    peek(2'd3, v); check("R3 overflow and compare flags", v, 16'h0300);
    check("R8 keep pin", {14'd0, tmr_out}, 16'h0000);
  endtask

  task automatic t_flag_clear;
    logic [15:0] v;
    wr(2'd3, 2'b11, 16'h0000);
    peek(2'd3, v); check("R9 clear without read ignored", v, 16'h0300);
    rd_strobe(2'd3);
    wr(2'd3, 2'b11, 16'h0000);
    peek(2'd3, v); check("R9 read then clear", v, 16'h0000);
  endtask

  task automatic t_match_clear;
    logic [15:0] v;
    wr(2'd2, 2'b01, 16'h006B);
    wr(2'd1, 2'b01, 16'h0003);
    wr(2'd0, 2'b01, 16'h0000);
    pulse(2, 3);
    @(negedge clk);
    peek(2'd0, v); check("R6 clear on match", v, 16'h0000);
    peek(2'd3, v); check("R4 compare flag", v, 16'h0001);
    check("R8 toggle high", {14'd0, tmr_out}, 16'h0002);
    pulse(2, 3);
    @(negedge clk);
    check("R8 toggle low", {14'd0, tmr_out}, 16'h0000);
  endtask

  task automatic t_blocked;
    logic [15:0] v;
    wr(2'd2, 2'b10, 16'h4100);
    wr(2'd1, 2'b10, 16'h4100);
    wr(2'd0, 2'b10, 16'h4000);
    @(negedge clk); src_pulse[0] = 1'b1;
    @(negedge clk); src_pulse[0] = 1'b0;
    bus_addr = 2'd1; bus_be = 2'b10; bus_wdata = 16'h6000; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_be = '0;
    @(negedge clk);
    peek(2'd3, v); check("R5 match lost during constant write", v, 16'h0001);
    check("R5 pin untouched", {14'd0, tmr_out}, 16'h0000);
    peek(2'd0, v); check("R5 counter reached value", v, 16'h4100);
    wr(2'd0, 2'b10, 16'h6000);
    @(negedge clk);
    peek(2'd3, v); check("R4 match after write", v, 16'h0101);
    check("R8 drive high", {14'd0, tmr_out}, 16'h0001);
  endtask

  task automatic t_cpu_wins;
    logic [15:0] v;
    @(negedge clk);
    bus_addr = 2'd0; bus_be = 2'b10; bus_wdata = 16'h1000; bus_wr = 1'b1;
    src_pulse[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; src_pulse[0] = 1'b0;
    peek(2'd0, v); check("R11 write beats count", v, 16'h1000);
    wr(2'd2, 2'b10, 16'h2100);
    wr(2'd0, 2'b10, 16'h6000);
    @(negedge clk);
    check("R8 drive low", {14'd0, tmr_out}, 16'h0000);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    wr(2'd2, 2'b01, 16'h0010);
    wr(2'd0, 2'b01, 16'h0033);
    pulse(2, 2);
    peek(2'd0, v); check("R2 source zero halts", v, 16'h6033);
    @(negedge clk); ext_rst[1] = 1'b1;
    @(negedge clk);
    peek(2'd0, v); check("R7 rising clear", v, 16'h6000);
    wr(2'd0, 2'b01, 16'h0055);
    @(negedge clk); ext_rst[1] = 1'b0;
    @(negedge clk);
    peek(2'd0, v); check("R7 falling ignored", v, 16'h6055);
    wr(2'd2, 2'b01, 16'h0018);
    wr(2'd0, 2'b01, 16'h0044);
    @(negedge clk); ext_rst[1] = 1'b1;
    @(negedge clk);
    peek(2'd0, v); check("R7 rising ignored", v, 16'h6044);
    @(negedge clk); ext_rst[1] = 1'b0;
    @(negedge clk);
    peek(2'd0, v); check("R7 falling clear", v, 16'h6000);
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    wr(2'd0, 2'b10, 16'hFF00);
    rd_strobe(2'd3);
    @(negedge clk);
    bus_addr = 2'd3; bus_be = 2'b10; bus_wdata = 16'h0000; bus_wr = 1'b1;
    src_pulse[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; src_pulse[0] = 1'b0;
    peek(2'd3, v); check("R9 clear one flag, set other", v, 16'h0201);
    rd_strobe(2'd3);
    wr(2'd0, 2'b10, 16'hFF00);
    @(negedge clk);
    bus_addr = 2'd3; bus_be = 2'b10; bus_wdata = 16'h0000; bus_wr = 1'b1;
    src_pulse[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; src_pulse[0] = 1'b0;
    peek(2'd3, v); check("R9 set wins over clear", v, 16'h0201);
    wr(2'd3, 2'b10, 16'h0000);
    peek(2'd3, v); check("R9 armed state ended", v, 16'h0201);
    rd_strobe(2'd3);
    wr(2'd3, 2'b10, 16'h0000);
    peek(2'd3, v); check("R9 final clear", v, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_overflow;
    t_flag_clear;
    t_match_clear;
    t_blocked;
    t_cpu_wins;
    t_ext;
    t_set_wins;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule